// File: doc/BRIEF.md
# Snoop-Watched Load Queue

This block keeps one entry for every load in flight, in program order. When a load issues, the core asks for a slot and receives its index. When the load reads memory, the core marks that slot as executed. When the load retires and its value has reached the register file, the core frees the oldest slot. Each entry keeps the 64-byte line address of its load. Every remote-store invalidation is compared against the executed entries.

Outside a transaction, a snoop hit cancels the matching loads. The block returns a per-slot cancel mask and clears the executed flag of those slots, so the core can replay them. Inside a transaction, retired entries stay in the queue and together form the read set. A snoop hit on any executed entry in that set, or an allocation request while every slot is taken, raises an abort request. The request holds until the core flushes the queue.

The controller has four states. OPEN is normal operation. DRAIN waits for the queue to empty before a transaction begins. TXN is the active transaction. ABORT holds a pending abort. The transitions are:
- begin-empty: OPEN to TXN when a transaction begins with the queue empty.
- begin-busy: OPEN to DRAIN when a transaction begins with the queue not empty.
- drained: DRAIN to TXN once the queue is empty.
- conflict: TXN to ABORT on a snoop hit.
- capacity: TXN to ABORT on an allocation request while the queue is full.
- commit: TXN to OPEN on commit.
- flush: any state to OPEN.

Top module: `snoop_load_queue`

## Requirements
- R1: Allocation slots are handed out in order, modulo DEPTH. `alloc_id` shows the slot the next accepted request takes. `alloc_ready` is low while all DEPTH slots are occupied, and a request made then takes no slot.
- R2: Outside a transaction, each `retire_valid` pulse frees the oldest entry, and that slot no longer matches snoops.
- R3: A snoop's line address is the address divided by 64. Outside a transaction, a snoop sets bit i of `cancel_mask` one cycle later for every executed entry i with the same line. `cancel_valid` is high with any set bit. The executed flag of every cancelled entry is cleared.
- R4: An entry that has not executed never matches. This includes an entry whose `exec_valid` arrives in the same cycle as the snoop.
- R5: Beginning a transaction with a non-empty queue enters DRAIN. In DRAIN, `alloc_ready` is low and retirement still frees entries. `txn_active` rises on the cycle after the queue becomes empty. With an empty queue, `txn_active` rises one cycle after `txn_begin`.
- R6: In TXN, retirement keeps the entry held. A snoop hit on any held executed entry, retired or not, raises `abort_req` one cycle later with `abort_capacity`=0, and produces no cancel.
- R7: In TXN, an allocation request while all slots are occupied raises `abort_req` one cycle later with `abort_capacity`=1.
- R8: A commit in TXN returns to OPEN one cycle later. It frees every entry that retired during the transaction, and unretired entries remain and keep matching.
- R9: `flush` empties the queue, returns to OPEN, drops any abort, and restarts slot numbering at 0.
- R10: `abort_req` stays high until `flush`, and `alloc_ready` is low while it is high.
- R11: After reset, the queue is empty, `alloc_id` is 0, `alloc_ready` is 1, and `cancel_valid`, `txn_active` and `abort_req` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Request a slot for an issuing load |
| alloc_addr | input | ADDR_W | Byte address of the issuing load |
| alloc_ready | output | 1 | A request is accepted this cycle |
| alloc_id | output | log2(DEPTH) | Slot the next accepted request takes |
| exec_valid | input | 1 | Load in `exec_id` has read its data |
| exec_id | input | log2(DEPTH) | Slot of the executed load |
| retire_valid | input | 1 | Oldest unretired load has retired |
| snoop_valid | input | 1 | Remote-store invalidation present |
| snoop_addr | input | ADDR_W | Byte address of the invalidated line |
| cancel_valid | output | 1 | At least one load cancelled |
| cancel_mask | output | DEPTH | Per-slot cancel flags |
| txn_begin | input | 1 | Start a transaction |
| txn_commit | input | 1 | Commit the transaction |
| flush | input | 1 | Clear the queue and any abort |
| txn_active | output | 1 | Transaction active |
| abort_req | output | 1 | Transaction must abort |
| abort_capacity | output | 1 | Abort cause: 1 = queue full, 0 = snoop conflict |

## Verification
`alloc_id` and `alloc_ready` follow the queue state in the same cycle. The bench reads them just before the edge on which a request is taken. `cancel_mask`, `cancel_valid`, `abort_req`, `abort_capacity` and `txn_active` come from registers. They change on the first edge after the causing input, so the bench drives each input on a falling edge, lets one rising edge pass, and samples on the next falling edge. The DRAIN exit adds one edge: the retirement that empties the queue lands first, and the state change follows. The bench therefore samples `txn_active` both between these two edges and after them.

// File: rtl/slq_pkg.sv
package slq_pkg;

    typedef enum logic [1:0] {
        ST_OPEN  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_TXN   = 2'd2,
        ST_ABORT = 2'd3
    } slq_state_e;

endpackage

// File: rtl/slq_entries.sv
module slq_entries #(
    parameter int DEPTH  = 64,
    parameter int LINE_W = 34,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_en,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic [LINE_W-1:0] alloc_line,
    input  logic              exec_en,
    input  logic [IDX_W-1:0]  exec_idx,
    input  logic              free_en,
    input  logic [IDX_W-1:0]  free_idx,
    input  logic              mark_en,
    input  logic [IDX_W-1:0]  mark_idx,
    input  logic              commit_en,
    input  logic [DEPTH-1:0]  clear_vec,
    input  logic [LINE_W-1:0] snoop_line,
    output logic [DEPTH-1:0]  match_vec
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic              live_q;
        logic              done_q;
        logic              held_q;
        logic [LINE_W-1:0] line_q;
        logic              pick_alloc;
        logic              pick_exec;
        logic              pick_free;
        logic              pick_mark;

        assign pick_alloc = alloc_en && (alloc_idx == IDX_W'(i));
        assign pick_exec  = exec_en  && (exec_idx  == IDX_W'(i));
        assign pick_free  = free_en  && (free_idx  == IDX_W'(i));
        assign pick_mark  = mark_en  && (mark_idx  == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live_q <= 1'b0;
                done_q <= 1'b0;
                held_q <= 1'b0;
                line_q <= '0;
            end else if (flush) begin
                live_q <= 1'b0;
                done_q <= 1'b0;
                held_q <= 1'b0;
            end else if (pick_alloc) begin
                live_q <= 1'b1;
                done_q <= 1'b0;
                held_q <= 1'b0;
                line_q <= alloc_line;
            end else if (pick_free || (commit_en && (held_q || pick_mark))) begin
                live_q <= 1'b0;
                done_q <= 1'b0;
                held_q <= 1'b0;
            end else begin
                if (pick_mark) begin
                    held_q <= 1'b1;
                end
                if (pick_exec && live_q) begin
                    done_q <= 1'b1;
                end else if (clear_vec[i]) begin
                    done_q <= 1'b0;
                end
            end
        end

        assign match_vec[i] = live_q && done_q && (line_q == snoop_line);

        AST_ALLOC_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
            (pick_alloc && !flush) |-> !live_q); // R1
        AST_EXEC_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
            done_q |-> live_q); // R4
        AST_HELD_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
            held_q |-> live_q); // R8
    end

endmodule

// File: rtl/slq_ctrl.sv
module slq_ctrl
    import slq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txn_begin,
    input  logic       txn_commit,
    input  logic       flush,
    input  logic       q_empty,
    input  logic       conflict,
    input  logic       overflow,
    output slq_state_e state_o,
    output logic       txn_active,
    output logic       abort_req,
    output logic       abort_capacity
);

    slq_state_e state_q;
    slq_state_e state_d;
    logic       cap_q;

    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = ST_OPEN;
        end else begin
            unique case (state_q)
                ST_OPEN: begin
                    if (txn_begin) begin
                        state_d = q_empty ? ST_TXN : ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (q_empty) begin
                        state_d = ST_TXN;
                    end
                end
                ST_TXN: begin
                    if (conflict || overflow) begin
                        state_d = ST_ABORT;
                    end else if (txn_commit) begin
                        state_d = ST_OPEN;
                    end
                end
                ST_ABORT: begin
                    state_d = ST_ABORT;
                end
                default: state_d = ST_OPEN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
            cap_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (flush) begin
                cap_q <= 1'b0;
            end else if (state_q == ST_TXN && state_d == ST_ABORT) begin
                cap_q <= !conflict;
            end
        end
    end

    always_comb begin
        state_o        = state_q;
        txn_active     = (state_q == ST_TXN);
        abort_req      = (state_q == ST_ABORT);
        abort_capacity = (state_q == ST_ABORT) && cap_q;
    end

    AST_ABORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_req && !flush) |=> abort_req); // R10
    AST_DRAIN_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && !q_empty && !flush) |=> (state_q == ST_DRAIN)); // R5
    AST_TXN_FROM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txn_active) |-> $past(q_empty)); // R5
    AST_FLUSH_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state_q == ST_OPEN)); // R9

endmodule

// File: rtl/snoop_load_queue.sv
module snoop_load_queue
    import slq_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int ADDR_W   = 40,
    parameter int LINE_OFF = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_valid,
    input  logic [ADDR_W-1:0]        alloc_addr,
    output logic                     alloc_ready,
    output logic [$clog2(DEPTH)-1:0] alloc_id,
    input  logic                     exec_valid,
    input  logic [$clog2(DEPTH)-1:0] exec_id,
    input  logic                     retire_valid,
    input  logic                     snoop_valid,
    input  logic [ADDR_W-1:0]        snoop_addr,
    output logic                     cancel_valid,
    output logic [DEPTH-1:0]         cancel_mask,
    input  logic                     txn_begin,
    input  logic                     txn_commit,
    input  logic                     flush,
    output logic                     txn_active,
    output logic                     abort_req,
    output logic                     abort_capacity
);

    localparam int IDX_W  = $clog2(DEPTH);
    localparam int PTR_W  = IDX_W + 1;
    localparam int LINE_W = ADDR_W - LINE_OFF;
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((64'd1 << LINE_OFF) - 64'd1);

    slq_state_e        state;
    logic [PTR_W-1:0]  head_q;
    logic [PTR_W-1:0]  rptr_q;
    logic [PTR_W-1:0]  tail_q;
    logic [PTR_W-1:0]  rptr_nx;
    logic [PTR_W-1:0]  count;
    logic              q_full;
    logic              q_empty;
    logic              open_mode;
    logic              alloc_take;
    logic              retire_free;
    logic              retire_mark;
    logic              commit_go;
    logic              conflict;
    logic              overflow;
    logic [LINE_W-1:0] alloc_line;
    logic [LINE_W-1:0] snoop_line;
    logic [DEPTH-1:0]  match_vec;
    logic [DEPTH-1:0]  hit_vec;
    logic [DEPTH-1:0]  clear_vec;
    logic [DEPTH-1:0]  cancel_q;

    assign alloc_line = LINE_W'((alloc_addr & ~OFF_MASK) >> LINE_OFF);
    assign snoop_line = LINE_W'((snoop_addr & ~OFF_MASK) >> LINE_OFF);

    assign count     = tail_q - head_q;
    assign q_full    = (count == PTR_W'(DEPTH));
    assign q_empty   = (count == '0);
    assign open_mode = (state == ST_OPEN) || (state == ST_DRAIN);

    assign alloc_ready = !q_full && ((state == ST_OPEN) || (state == ST_TXN));
    assign alloc_id    = tail_q[IDX_W-1:0];

    assign alloc_take  = alloc_valid && alloc_ready && !flush;
    assign retire_free = retire_valid && open_mode && !q_empty && !flush;
    assign retire_mark = retire_valid && (state == ST_TXN) && (rptr_q != tail_q) && !flush;
    assign rptr_nx     = rptr_q + PTR_W'(retire_mark);

    assign hit_vec   = snoop_valid ? match_vec : '0;
    assign conflict  = (state == ST_TXN) && (|hit_vec);
    assign overflow  = (state == ST_TXN) && alloc_valid && q_full;
    assign commit_go = (state == ST_TXN) && txn_commit && !conflict && !overflow && !flush;
    assign clear_vec = open_mode ? hit_vec : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q   <= '0;
            rptr_q   <= '0;
            tail_q   <= '0;
            cancel_q <= '0;
        end else if (flush) begin
            head_q   <= '0;
            rptr_q   <= '0;
            tail_q   <= '0;
            cancel_q <= '0;
        end else begin
            cancel_q <= clear_vec;
            if (alloc_take) begin
                tail_q <= tail_q + PTR_W'(1);
            end
            if (retire_free) begin
                head_q <= head_q + PTR_W'(1);
                rptr_q <= rptr_q + PTR_W'(1);
            end else if (commit_go) begin
                head_q <= rptr_nx;
                rptr_q <= rptr_nx;
            end else begin
                rptr_q <= rptr_nx;
            end
        end
    end

    assign cancel_mask  = cancel_q;
    assign cancel_valid = |cancel_q;

    slq_entries #(
        .DEPTH (DEPTH),
        .LINE_W(LINE_W),
        .IDX_W (IDX_W)
    ) u_entries (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .alloc_en  (alloc_take),
        .alloc_idx (tail_q[IDX_W-1:0]),
        .alloc_line(alloc_line),
        .exec_en   (exec_valid && !flush),
        .exec_idx  (exec_id),
        .free_en   (retire_free),
        .free_idx  (head_q[IDX_W-1:0]),
        .mark_en   (retire_mark),
        .mark_idx  (rptr_q[IDX_W-1:0]),
        .commit_en (commit_go),
        .clear_vec (clear_vec),
        .snoop_line(snoop_line),
        .match_vec (match_vec)
    );

    slq_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .txn_begin     (txn_begin),
        .txn_commit    (txn_commit),
        .flush         (flush),
        .q_empty       (q_empty),
        .conflict      (conflict),
        .overflow      (overflow),
        .state_o       (state),
        .txn_active    (txn_active),
        .abort_req     (abort_req),
        .abort_capacity(abort_capacity)
    );

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= PTR_W'(DEPTH)); // R1
    AST_DRAIN_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> !alloc_ready); // R5
    AST_NO_CANCEL_IN_TXN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TXN) |=> !cancel_valid); // R6
    AST_RPTR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (PTR_W'(rptr_q - head_q) <= count)); // R8
    AST_ABORT_BLOCKS_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> !alloc_ready); // R10

endmodule

// File: tb/snoop_load_queue_bench.sv
`timescale 1ns/1ps
module snoop_load_queue_bench;

    localparam int DEPTH = 8;
    localparam int AW    = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             alloc_valid = 1'b0;
    logic [AW-1:0]    alloc_addr = '0;
    logic             alloc_ready;
    logic [2:0]       alloc_id;
    logic             exec_valid = 1'b0;
    logic [2:0]       exec_id = '0;
    logic             retire_valid = 1'b0;
    logic             snoop_valid = 1'b0;
    logic [AW-1:0]    snoop_addr = '0;
    logic             cancel_valid;
    logic [DEPTH-1:0] cancel_mask;
    logic             txn_begin = 1'b0;
    logic             txn_commit = 1'b0;
    logic             flush = 1'b0;
    logic             txn_active;
    logic             abort_req;
    logic             abort_capacity;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    snoop_load_queue #(.DEPTH(DEPTH), .ADDR_W(AW), .LINE_OFF(6)) u_snoop_load_queue (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr),
        .alloc_ready(alloc_ready), .alloc_id(alloc_id),
        .exec_valid(exec_valid), .exec_id(exec_id),
        .retire_valid(retire_valid),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .cancel_valid(cancel_valid), .cancel_mask(cancel_mask),
        .txn_begin(txn_begin), .txn_commit(txn_commit), .flush(flush),
        .txn_active(txn_active), .abort_req(abort_req), .abort_capacity(abort_capacity)
    );

    // op codes: 0 alloc (exp = slot), 1 exec (addr = slot), 2 retire, 3 snoop (exp = mask)
    localparam logic [43:0] VEC [16] = '{
        {4'd0, 32'h1000, 8'h00},
        {4'd0, 32'h1040, 8'h01},
        {4'd0, 32'h1008, 8'h02},
        {4'd1, 32'h0000, 8'h00},
        {4'd1, 32'h0001, 8'h00},
        {4'd3, 32'h1030, 8'h01},
        {4'd3, 32'h1030, 8'h00},
        {4'd1, 32'h0000, 8'h00},
        {4'd1, 32'h0002, 8'h00},
        {4'd3, 32'h1000, 8'h05},
        {4'd3, 32'h107F, 8'h02},
        {4'd3, 32'h2000, 8'h00},
        {4'd1, 32'h0000, 8'h00},
        {4'd1, 32'h0002, 8'h00},
        {4'd2, 32'h0000, 8'h00},
        {4'd3, 32'h1010, 8'h04}   // R2: slot 0 retired, only slot 2 left on that line
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_alloc(input logic [31:0] a, input logic [2:0] exp_id);
        chk("R1 ready", 32'(alloc_ready), 32'd1);
        chk("R1 id", 32'(alloc_id), 32'(exp_id));
        alloc_valid = 1'b1; alloc_addr = a;
        tick;
        alloc_valid = 1'b0;
    endtask

    task automatic do_exec(input logic [2:0] id);
        exec_valid = 1'b1; exec_id = id;
        tick;
        exec_valid = 1'b0;
    endtask

    task automatic do_retire;
        retire_valid = 1'b1;
        tick;
        retire_valid = 1'b0;
    endtask

    task automatic do_snoop(input logic [31:0] a, input logic [7:0] exp, input string req);
        snoop_valid = 1'b1; snoop_addr = a;
        tick;
        snoop_valid = 1'b0;
        chk(req, 32'(cancel_mask), 32'(exp));
        chk(req, 32'(cancel_valid), 32'(exp != 0));
    endtask

    task automatic pulse_flush;
        flush = 1'b1;
        tick;
        flush = 1'b0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 ready", 32'(alloc_ready), 32'd1);
        chk("R11 id", 32'(alloc_id), 32'd0);
        chk("R11 cancel", 32'(cancel_valid), 32'd0);
        chk("R11 txn", 32'(txn_active), 32'd0);
        chk("R11 abort", 32'(abort_req), 32'd0);

        for (int i = 0; i < 16; i++) begin
            unique case (VEC[i][43:40])
                4'd0: do_alloc(VEC[i][39:8], VEC[i][2:0]);
                4'd1: do_exec(VEC[i][10:8]);
                4'd2: do_retire();
                default: do_snoop(VEC[i][39:8], VEC[i][7:0], "R3 snoop");
            endcase
        end

        // R4: exec in the same cycle as the snoop does not match
        exec_valid = 1'b1; exec_id = 3'd1;
        do_snoop(32'h1040, 8'h00, "R4 same-cycle exec");
        exec_valid = 1'b0;
        do_snoop(32'h1040, 8'h02, "R4 after exec");

        // R1 fill to full (slots 1,2 live, tail at 3)
        for (int k = 0; k < 6; k++) do_alloc(32'h7000 + 32'(k * 64), 3'(3 + k));
        chk("R1 full ready", 32'(alloc_ready), 32'd0);
        alloc_valid = 1'b1; alloc_addr = 32'h9000;
        tick;
        alloc_valid = 1'b0;
        chk("R1 full id", 32'(alloc_id), 32'd1);
        do_retire();
        chk("R2 freed ready", 32'(alloc_ready), 32'd1);
        chk("R2 freed id", 32'(alloc_id), 32'd1);
        do_exec(3'd3);
        pulse_flush();
        chk("R9 id", 32'(alloc_id), 32'd0);
        do_snoop(32'h7000, 8'h00, "R9 flushed entry");

        // R5 drain
        do_alloc(32'h3000, 3'd0);
        txn_begin = 1'b1;
        tick;
        txn_begin = 1'b0;
        chk("R5 drain txn", 32'(txn_active), 32'd0);
        chk("R5 drain ready", 32'(alloc_ready), 32'd0);
        do_retire();
        chk("R5 empty not yet", 32'(txn_active), 32'd0);
        tick;
        chk("R5 txn on", 32'(txn_active), 32'd1);

        // R4 / R6 conflict in txn
        do_alloc(32'h4000, 3'd1);
        snoop_valid = 1'b1; snoop_addr = 32'h4000;
        tick;
        snoop_valid = 1'b0;
        chk("R4 unexecuted no abort", 32'(abort_req), 32'd0);
        do_exec(3'd1);
        do_retire();
        do_snoop(32'h4020, 8'h00, "R6 no cancel");
        chk("R6 abort", 32'(abort_req), 32'd1);
        chk("R6 cause", 32'(abort_capacity), 32'd0);
        tick;
        chk("R10 held", 32'(abort_req), 32'd1);
        chk("R10 ready", 32'(alloc_ready), 32'd0);
        pulse_flush();
        chk("R9 abort cleared", 32'(abort_req), 32'd0);
        chk("R9 txn off", 32'(txn_active), 32'd0);

        // R8 commit
        txn_begin = 1'b1;
        tick;
        txn_begin = 1'b0;
        chk("R5 empty begin", 32'(txn_active), 32'd1);
        do_alloc(32'h5000, 3'd0);
        do_alloc(32'h5040, 3'd1);
        do_exec(3'd0);
        do_exec(3'd1);
        do_retire();
        txn_commit = 1'b1;
        tick;
        txn_commit = 1'b0;
        chk("R8 txn off", 32'(txn_active), 32'd0);
        chk("R8 abort", 32'(abort_req), 32'd0);
        chk("R8 id", 32'(alloc_id), 32'd2);
        do_snoop(32'h5000, 8'h00, "R8 retired freed");
        do_snoop(32'h5040, 8'h02, "R8 unretired kept");

        // R7 capacity abort
        pulse_flush();
        txn_begin = 1'b1;
        tick;
        txn_begin = 1'b0;
        for (int k = 0; k < 8; k++) do_alloc(32'h6000 + 32'(k * 64), 3'(k));
        chk("R7 full", 32'(alloc_ready), 32'd0);
        alloc_valid = 1'b1; alloc_addr = 32'h8000;
        tick;
        alloc_valid = 1'b0;
        chk("R7 abort", 32'(abort_req), 32'd1);
        chk("R7 cause", 32'(abort_capacity), 32'd1);
        pulse_flush();
        chk("R9 cause cleared", 32'(abort_capacity), 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule